// File: doc/BRIEF.md
# Clock-Ratio Detect and Init Sequencer

This controller governs power-up, clock qualification and power-down for the digital section of a stereo audio converter. It runs on a free-running control clock and watches the converter's master clock and frame (left/right) clock as plain sampled inputs. While no master clock is present the datapath is held in reset with its output muted. When master-clock activity first appears, a strap input is sampled once to fix the role. In the clock-provider role the clock ratio is fixed at 256. In the clock-follower role the controller counts master-clock rising edges over one frame period and classifies the ratio.

Once the ratio is known, the reference enable rises and the datapath leaves reset. A fixed settling interval then runs with the serial output muted at a role-dependent level, and after it the output is released. Losing the master clock in either role, or the frame clock in the follower role, drops the block back to power-down. When the clocks return the sequence runs again, and in the follower role it measures the ratio afresh.

Top module: `clkseq_init_ctrl`

## Requirements
- R1: After reset, `dp_rst_o`=1, `ref_en_o`=0, `mute_o`=1, `ratio_o`=0, `mode_slave_o`=0, `mute_level_o`=0 and `lrck_run_o`=0, and these hold until master-clock activity is seen.
- R2: The role is taken from `strap_master_i` (1 = provider, 0 = follower) at the first master-clock activity after reset. It is shown on `mode_slave_o` (1 = follower) and is not changed by later strap values.
- R3: In the provider role `ratio_o` becomes 1 (256x) at the start of initialization. `lrck_run_o` rises on the 127th master-clock rising edge counted from that start and is never high in the follower role.
- R4: In the follower role the measured count is the number of master-clock rising edges between two consecutive frame-clock rising edges. A count within ±`RATIO_TOL` of 256, 384 or 512 gives `ratio_o` code 1, 2 or 3.
- R5: Initialization lasts `SETTLE_FRAMES` frames, counted as frame-clock rising edges in the follower role and as 256 master-clock rising edges each in the provider role. Then `mute_o` falls.
- R6: While initialization is running, `mute_level_o` is 0 in the provider role and 1 in the follower role.
- R7: If the master clock shows no edge for `MCLK_TIMEOUT` control cycles, or the frame clock shows none for `LRCK_TIMEOUT` cycles in the follower role, the block returns to power-down (`dp_rst_o`=1, `ref_en_o`=0, `mute_o`=1, `ratio_o`=0, `lrck_run_o`=0). It re-initializes when the clocks return.
- R8: A follower re-initialization after a power-down re-measures the ratio and adopts a new ratio if it has changed.
- R9: A measured count outside every tolerance band is rejected. The block stays powered down with `ref_en_o`=0 and `ratio_o`=0 and measures again over the following frame.
- R10: `ref_en_o` rises and `dp_rst_o` falls in the same cycle as `ratio_o` becomes non-zero. Both hold until power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running control clock |
| rst | input | 1 | Synchronous active-high reset (initial power-up) |
| mclk_i | input | 1 | Master clock, sampled as data |
| lrck_i | input | 1 | Frame clock, sampled as data (follower role) |
| strap_master_i | input | 1 | Role strap: 1 selects provider role |
| mode_slave_o | output | 1 | Latched role, 1 = follower |
| ratio_o | output | 2 | Ratio code: 0 none, 1 = 256x, 2 = 384x, 3 = 512x |
| dp_rst_o | output | 1 | Datapath reset |
| ref_en_o | output | 1 | Reference/analog power enable |
| mute_o | output | 1 | Serial output muted |
| mute_level_o | output | 1 | Level the muted serial output is held at |
| lrck_run_o | output | 1 | Provider role: frame-clock output enabled |

## Verification
An input clock edge reaches the control state two control cycles later, through the synchronizer. A frame decision lands one cycle after that, and the state change and its outputs land one cycle further on, so `ref_en_o` follows the deciding frame edge by about four cycles. Rather than depending on those absolute delays, the bench counts the clock edges it drives between the rise of `ref_en_o` and the fall of `mute_o`. The fixed latency drops out of that count, so the frame count matches exactly in the follower role and within a few master-clock edges in the provider role. Power-down checks wait the full timeout plus a margin. All outputs are sampled a quarter period after the rising edge.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

    typedef enum logic [1:0] {
        RATIO_NONE = 2'd0,
        RATIO_256  = 2'd1,
        RATIO_384  = 2'd2,
        RATIO_512  = 2'd3
    } ratio_e;

    typedef enum logic {
        MODE_MASTER = 1'b0,
        MODE_SLAVE  = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_MEAS   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_RUN    = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic rise;
        logic alive;
    } clk_mon_t;

    localparam int unsigned FS_LOW   = 256;
    localparam int unsigned FS_MID   = 384;
    localparam int unsigned FS_HIGH  = 512;
    localparam int unsigned PROV_DIV = 256;

    function automatic logic in_band(input logic [15:0] v,
                                     input logic [15:0] centre,
                                     input logic [15:0] tol);
        logic [16:0] lo_ok;
        logic [16:0] hi_ok;
        lo_ok = {1'b0, v} + {1'b0, tol};
        hi_ok = {1'b0, centre} + {1'b0, tol};
        return (lo_ok >= {1'b0, centre}) && ({1'b0, v} <= hi_ok);
    endfunction

    function automatic ratio_e classify_ratio(input logic [15:0] cnt,
                                              input logic [15:0] tol);
        ratio_e r;
        r = RATIO_NONE;
        if (in_band(cnt, 16'(FS_LOW), tol))       r = RATIO_256;
        else if (in_band(cnt, 16'(FS_MID), tol))  r = RATIO_384;
        else if (in_band(cnt, 16'(FS_HIGH), tol)) r = RATIO_512;
        return r;
    endfunction

endpackage

// File: rtl/clkseq_edge_mon.sv
module clkseq_edge_mon
    import clkseq_pkg::*;
#(
    parameter int unsigned TIMEOUT = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sig_i,
    output clk_mon_t mon_o
);
    localparam int unsigned TW = $clog2(TIMEOUT + 1);
    localparam logic [TW-1:0] IDLE_MAX = TW'(TIMEOUT);

    logic [2:0]    sh;
    logic [TW-1:0] idle;
    logic          any_edge;

    assign any_edge = sh[2] ^ sh[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            idle <= IDLE_MAX;
        end else begin
            sh <= {sh[1:0], sig_i};
            if (any_edge)
                idle <= '0;
            else if (idle != IDLE_MAX)
                idle <= idle + 1'b1;
        end
    end

    always_comb begin
        mon_o.rise  = sh[1] & ~sh[2];
        mon_o.alive = (idle != IDLE_MAX);
    end

    // R7: an observed edge always makes the clock count as present
    assert_edge_revives_R7: assert property (@(posedge clk) disable iff (rst)
        any_edge |=> mon_o.alive);

endmodule

// File: rtl/clkseq_ratio_meas.sv
module clkseq_ratio_meas
    import clkseq_pkg::*;
#(
    parameter int unsigned TOL = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   clr_i,
    input  logic   mclk_rise_i,
    input  logic   lrck_rise_i,
    output logic   done_o,
    output ratio_e ratio_o
);
    localparam int unsigned CAP = FS_HIGH + TOL + 1;
    localparam int unsigned CW  = $clog2(CAP + 2);
    localparam logic [CW-1:0] CNT_CAP = CW'(CAP);

    logic [CW-1:0] cnt;
    logic [CW-1:0] total;
    logic          armed;

    assign total = cnt + (mclk_rise_i ? CW'(1) : CW'(0));

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt     <= '0;
            armed   <= 1'b0;
            done_o  <= 1'b0;
            ratio_o <= RATIO_NONE;
        end else begin
            done_o <= 1'b0;
            if (lrck_rise_i) begin
                armed <= 1'b1;
                cnt   <= '0;
                if (armed) begin
                    done_o  <= 1'b1;
                    ratio_o <= classify_ratio(16'(total), 16'(TOL));
                end
            end else if (mclk_rise_i && cnt != CNT_CAP) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R4: a verdict only follows a full frame that began while armed
    assert_verdict_after_arm_R4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(armed) && $past(lrck_rise_i));

endmodule

// File: rtl/clkseq_frame_timer.sv
module clkseq_frame_timer #(
    parameter int unsigned FRAMES     = 11265,
    parameter int unsigned DIV        = 256,
    parameter int unsigned LRCK_START = 127
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic master_i,
    input  logic mclk_rise_i,
    input  logic lrck_rise_i,
    output logic lrck_run_o,
    output logic done_o
);
    localparam int unsigned DW = $clog2(DIV);
    localparam int unsigned FW = $clog2(FRAMES + 1);
    localparam logic [DW-1:0] DIV_LAST   = DW'(DIV - 1);
    localparam logic [DW-1:0] START_LAST = DW'(LRCK_START - 1);
    localparam logic [FW-1:0] FRAME_END  = FW'(FRAMES);

    logic [DW-1:0] div;
    logic [FW-1:0] frames;
    logic          started;
    logic          tick;

    assign tick = master_i ? (mclk_rise_i && div == DIV_LAST) : lrck_rise_i;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            div     <= '0;
            frames  <= '0;
            started <= 1'b0;
        end else begin
            if (mclk_rise_i) begin
                div <= (div == DIV_LAST) ? '0 : div + 1'b1;
                if (master_i && div == START_LAST)
                    started <= 1'b1;
            end
            if (tick && frames != FRAME_END)
                frames <= frames + 1'b1;
        end
    end

    assign done_o     = (frames == FRAME_END);
    assign lrck_run_o = started;

    // R3: the provider frame clock starts only in the provider role
    assert_lrck_run_provider_R3: assert property (@(posedge clk) disable iff (rst)
        lrck_run_o |-> master_i);

endmodule

// File: rtl/clkseq_init_ctrl.sv
module clkseq_init_ctrl
    import clkseq_pkg::*;
#(
    parameter int unsigned SETTLE_FRAMES = 11265,
    parameter int unsigned MCLK_TIMEOUT  = 16,
    parameter int unsigned LRCK_TIMEOUT  = 2048,
    parameter int unsigned RATIO_TOL     = 4,
    parameter int unsigned LRCK_START    = 127
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mclk_i,
    input  logic       lrck_i,
    input  logic       strap_master_i,
    output logic       mode_slave_o,
    output logic [1:0] ratio_o,
    output logic       dp_rst_o,
    output logic       ref_en_o,
    output logic       mute_o,
    output logic       mute_level_o,
    output logic       lrck_run_o
);
    clk_mon_t   mclk_mon;
    clk_mon_t   lrck_mon;
    seq_state_e state;
    mode_e      mode_q;
    ratio_e     ratio_q;
    ratio_e     meas_ratio;
    logic       known;
    logic       clocks_ok;
    logic       meas_done;
    logic       settle_done;
    logic       timer_run;

    clkseq_edge_mon #(.TIMEOUT(MCLK_TIMEOUT)) u_mclk_mon (
        .clk(clk), .rst(rst), .sig_i(mclk_i), .mon_o(mclk_mon)
    );

    clkseq_edge_mon #(.TIMEOUT(LRCK_TIMEOUT)) u_lrck_mon (
        .clk(clk), .rst(rst), .sig_i(lrck_i), .mon_o(lrck_mon)
    );

    clkseq_ratio_meas #(.TOL(RATIO_TOL)) u_meas (
        .clk(clk), .rst(rst),
        .clr_i(state != ST_MEAS),
        .mclk_rise_i(mclk_mon.rise),
        .lrck_rise_i(lrck_mon.rise),
        .done_o(meas_done),
        .ratio_o(meas_ratio)
    );

    assign timer_run = (state == ST_SETTLE) || (state == ST_RUN);

    clkseq_frame_timer #(
        .FRAMES(SETTLE_FRAMES), .DIV(PROV_DIV), .LRCK_START(LRCK_START)
    ) u_timer (
        .clk(clk), .rst(rst),
        .run_i(timer_run),
        .master_i(mode_q == MODE_MASTER),
        .mclk_rise_i(mclk_mon.rise),
        .lrck_rise_i(lrck_mon.rise),
        .lrck_run_o(lrck_run_o),
        .done_o(settle_done)
    );

    assign clocks_ok = mclk_mon.alive && ((mode_q == MODE_MASTER) || lrck_mon.alive);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_OFF;
            mode_q  <= MODE_MASTER;
            known   <= 1'b0;
            ratio_q <= RATIO_NONE;
        end else begin
            unique case (state)
                ST_OFF: begin
                    if (!known) begin
                        if (mclk_mon.alive) begin
                            known  <= 1'b1;
                            mode_q <= strap_master_i ? MODE_MASTER : MODE_SLAVE;
                        end
                    end else if (clocks_ok) begin
                        if (mode_q == MODE_MASTER) begin
                            ratio_q <= RATIO_256;
                            state   <= ST_SETTLE;
                        end else begin
                            state <= ST_MEAS;
                        end
                    end
                end
                ST_MEAS: begin
                    if (!clocks_ok) begin
                        state <= ST_OFF;
                    end else if (meas_done && meas_ratio != RATIO_NONE) begin
                        ratio_q <= meas_ratio;
                        state   <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (!clocks_ok) begin
                        ratio_q <= RATIO_NONE;
                        state   <= ST_OFF;
                    end else if (settle_done) begin
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (!clocks_ok) begin
                        ratio_q <= RATIO_NONE;
                        state   <= ST_OFF;
                    end
                end
                default: state <= ST_OFF;
            endcase
        end
    end

    always_comb begin
        mode_slave_o = (mode_q == MODE_SLAVE);
        ratio_o      = ratio_q;
        dp_rst_o     = !timer_run;
        ref_en_o     = timer_run;
        mute_o       = (state != ST_RUN);
        mute_level_o = known && (mode_q == MODE_SLAVE);
    end

    // R2: once latched, the role never changes
    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        (known && $past(known)) |-> $stable(mode_q));

    // R7: loss of the master clock while powered forces power-down
    assert_mclk_loss_down_R7: assert property (@(posedge clk) disable iff (rst)
        (timer_run && !mclk_mon.alive) |=> (state == ST_OFF));

    // R9: a rejected count keeps the block measuring
    assert_reject_stays_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MEAS && clocks_ok && meas_done && meas_ratio == RATIO_NONE)
        |=> (state == ST_MEAS) && !ref_en_o);

    // R10: the reference is only enabled with a known ratio
    assert_ref_has_ratio_R10: assert property (@(posedge clk) disable iff (rst)
        ref_en_o |-> (ratio_q != RATIO_NONE));

endmodule

// File: tb/clkseq_init_ctrl_test.sv
module clkseq_init_ctrl_test;
    import clkseq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 4;
    localparam int MTO        = 16;
    localparam int LTO        = 2048;
    localparam int TOL        = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mclk = 1'b0;
    logic lrck = 1'b0;
    logic strap = 1'b0;
    logic       mode_slave, dp_rst, ref_en, mute, mute_level, lrck_run;
    logic [1:0] ratio;

    clkseq_init_ctrl #(
        .SETTLE_FRAMES(SETTLE), .MCLK_TIMEOUT(MTO), .LRCK_TIMEOUT(LTO),
        .RATIO_TOL(TOL), .LRCK_START(127)
    ) uut (
        .clk(clk), .rst(rst), .mclk_i(mclk), .lrck_i(lrck),
        .strap_master_i(strap), .mode_slave_o(mode_slave), .ratio_o(ratio),
        .dp_rst_o(dp_rst), .ref_en_o(ref_en), .mute_o(mute),
        .mute_level_o(mute_level), .lrck_run_o(lrck_run)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Clock stimulus: master clock period is 2 control cycles
    bit mclk_on = 0;
    bit lrck_on = 0;
    int lrck_half = 256;
    int lcnt = 0;
    int mclk_rises = 0;
    int lrck_rises = 0;

    always @(negedge clk) begin
        if (mclk_on) begin
            mclk <= ~mclk;
            if (!mclk) mclk_rises <= mclk_rises + 1;
        end
        if (lrck_on) begin
            if (lcnt >= lrck_half - 1) begin
                lrck <= ~lrck;
                lcnt <= 0;
                if (!lrck) lrck_rises <= lrck_rises + 1;
            end else begin
                lcnt <= lcnt + 1;
            end
        end
    end

    // Scoreboard
    typedef struct {
        bit         slave;
        logic [1:0] code;
    } lock_t;
    lock_t exp_q[$];

    task automatic expect_lock(input bit slave, input logic [1:0] code);
        lock_t e;
        e.slave = slave;
        e.code  = code;
        exp_q.push_back(e);
    endtask

    // Monitor: samples a quarter period after each rising edge
    initial begin
        logic p_mute, p_ref, p_run;
        int snap_m, snap_l;
        lock_t e;
        p_mute = 1'b1; p_ref = 1'b0; p_run = 1'b0;
        snap_m = 0; snap_l = 0;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (!rst) begin
                if (ref_en && !p_ref) begin
                    snap_m = mclk_rises;
                    snap_l = lrck_rises;
                    if (exp_q.size() > 0)
                        check(mute_level == exp_q[0].slave, "R6 mute level", mute_level, exp_q[0].slave);
                    check(ratio != 2'd0 && !dp_rst, "R10 ratio with ref", ratio, 1);
                end
                if (lrck_run && !p_run)
                    check((mclk_rises - snap_m) >= 124 && (mclk_rises - snap_m) <= 130,
                          "R3 lrck start", mclk_rises - snap_m, 127);
                if (!mute && p_mute) begin
                    if (exp_q.size() == 0) begin
                        check(0, "R5 unexpected release", 0, 1);
                    end else begin
                        e = exp_q.pop_front();
                        check(mode_slave == e.slave, "R2 mode at lock", mode_slave, e.slave);
                        check(ratio == e.code, e.slave ? "R4 ratio code" : "R3 ratio code", ratio, e.code);
                        if (e.slave)
                            check(lrck_rises - snap_l == SETTLE, "R5 settle frames", lrck_rises - snap_l, SETTLE);
                        else
                            check((mclk_rises - snap_m) >= SETTLE*256 - 4 && (mclk_rises - snap_m) <= SETTLE*256 + 4,
                                  "R5 settle edges", mclk_rises - snap_m, SETTLE*256);
                    end
                end
                p_mute = mute; p_ref = ref_en; p_run = lrck_run;
            end
        end
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        while (exp_q.size() != 0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        check(exp_q.size() == 0, req, exp_q.size(), 0);
        wait_clks(4);
    endtask

    task automatic check_down(input string req);
        check(dp_rst && !ref_en && mute && ratio == 2'd0 && !lrck_run, req,
              {dp_rst, ref_en, mute, lrck_run}, 4'b1010);
    endtask

    task automatic finish_test;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_test();
    end

    initial begin
        // R1: reset state, follower strap
        strap = 1'b0;
        wait_clks(5);
        rst = 1'b0;
        wait_clks(3);
        check(dp_rst && !ref_en && mute && ratio == 0 && !mode_slave && !mute_level && !lrck_run,
              "R1 reset state", {dp_rst, ref_en, mute, mode_slave}, 4'b1010);
        wait_clks(100);
        check_down("R1 idle without mclk");

        // Master clock alone: role latched, still powered down
        mclk_on = 1;
        wait_clks(300);
        check(mode_slave == 1'b1, "R2 strap latched", mode_slave, 1);
        check_down("R7 no frame clock");
        strap = 1'b1;
        wait_clks(10);
        check(mode_slave == 1'b1, "R2 strap ignored later", mode_slave, 1);

        // Follower lock at 384x
        lrck_half = 384;
        expect_lock(1'b1, 2'(RATIO_384));
        lrck_on = 1;
        drain("R4 lock 384");
        check(lrck_run == 1'b0, "R3 no lrck run in follower", lrck_run, 0);

        // Frame clock loss, then return at 512x
        lrck_on = 0;
        wait_clks(LTO + 20);
        check_down("R7 frame clock loss");
        lrck_half = 512;
        expect_lock(1'b1, 2'(RATIO_512));
        lrck_on = 1;
        drain("R8 relock 512");

        // Illegal ratio rejected, then an edge-of-band ratio accepted
        lrck_on = 0;
        wait_clks(LTO + 20);
        lrck_half = 300;
        lrck_on = 1;
        wait_clks(3000);
        check_down("R9 reject 300");
        lrck_half = 256 + TOL;
        expect_lock(1'b1, 2'(RATIO_256));
        drain("R4 tolerance edge 260");

        // Master clock loss in follower role
        mclk_on = 0;
        wait_clks(MTO + 10);
        check_down("R7 mclk loss follower");
        expect_lock(1'b1, 2'(RATIO_256));
        mclk_on = 1;
        drain("R7 follower restart");

        // Provider role after a fresh power-up
        rst = 1'b1;
        mclk_on = 0;
        lrck_on = 0;
        strap = 1'b1;
        wait_clks(5);
        rst = 1'b0;
        wait_clks(3);
        check_down("R1 reset again");
        expect_lock(1'b0, 2'(RATIO_256));
        mclk_on = 1;
        drain("R3 provider lock");
        check(lrck_run == 1'b1, "R3 lrck running", lrck_run, 1);

        mclk_on = 0;
        wait_clks(MTO + 10);
        check_down("R7 provider mclk loss");
        expect_lock(1'b0, 2'(RATIO_256));
        mclk_on = 1;
        drain("R7 provider restart");

        finish_test();
    end

endmodule